// File: doc/BRIEF.md
# Request-Grant Latency Monitor

This block is a synthesizable monitor placed beside a two-port arbiter. For each port it watches a one-bit request and the one-bit grant of that same port. Every cycle in which a request is sampled high starts a new pending transaction. Each pending transaction must be answered by a grant on its own port between one and four cycles later. Grants retire pending transactions strictly in the order the requests were raised.

Each port keeps a short circular queue of age counters. Four kinds of violation are detected per port and recorded on sticky error vectors, where bit p belongs to port p:

- **Orphan:** a grant with nothing pending.
- **Too early:** a grant in the same cycle as its request.
- **Late:** the oldest request reaches its fourth cycle without a grant.
- **Overflow:** a request arrives while the queue is full.

The error bits stay set until a synchronous clear is applied. The monitor never drives the arbiter; it only observes it.

Top module: `reqgnt_lat_mon`

## Requirements
- R1: While `rst_n` is low at a rising edge, all error vectors read 0 after that edge, and both queues are emptied. A grant after reset with no new request is therefore an orphan.
- R2: A grant on port p that arrives 1, 2, 3 or 4 cycles after the oldest pending request on port p retires that request and sets no error bit.
- R3: Grants pair with pending requests in arrival order. With requests in cycles 1 and 3 and grants in cycles 4 and 6, no error is raised.
- R4: A grant on port p with no request pending on p, and no request on p in the same cycle, sets bit p of `err_orphan_o`.
- R5: A grant on port p in the same cycle as a request on p, with nothing already pending on p, sets bit p of `err_early_o`. That request is consumed and not queued.
- R6: If the oldest pending request on port p reaches 4 cycles of age and no grant arrives in that cycle, bit p of `err_late_o` is set and that request is discarded. A request with age 3 raises no late error.
- R7: A request on port p while DEPTH requests are pending on p, and no request on p is retired in that cycle, sets bit p of `err_ovf_o` and is dropped. If a retirement happens in the same cycle, the request is queued without error.
- R8: Every error bit holds its value until a cycle with `clr_i` high, which clears all bits. An error detected in the same cycle as `clr_i` is still recorded.
- R9: The ports are independent. A request or grant on one port never retires, ages or flags anything on the other port.
- R10: Several requests may be pending on one port at once. One new entry is added for each cycle in which the request is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| clr_i | input | 1 | Synchronous clear of all sticky error bits |
| req_i | input | NUM_PORTS | Request per port, one bit per port |
| gnt_i | input | NUM_PORTS | Grant per port, one bit per port |
| err_orphan_o | output | NUM_PORTS | Sticky orphan-grant error, bit p = port p |
| err_early_o | output | NUM_PORTS | Sticky too-early grant error, bit p = port p |
| err_late_o | output | NUM_PORTS | Sticky timeout error, bit p = port p |
| err_ovf_o | output | NUM_PORTS | Sticky queue-overflow error, bit p = port p |

## Verification
Every error bit is set by the rising edge that samples the offending cycle, so it is due at the falling edge right after that edge. The bench drives inputs at falling edges and compares all outputs with its reference model at the next falling edge.

A late error therefore appears at the falling edge after the fourth cycle following the request. The directed late test reads the flag both one cycle before that edge and at that edge.

Overflow cannot occur with a queue at least as deep as the window. For that reason a second instance with a two-entry queue shares the same stimulus and is checked against the same model with its own depth.

// File: rtl/rgl_pkg.sv
// Package for the request-grant latency monitor.
// Holds the per-port event record that trackers hand to the top.
package rgl_pkg;

    // One-cycle violation pulses raised by a port tracker
    typedef struct packed {
        logic orphan;   // grant with nothing pending
        logic early;    // grant in the same cycle as its request
        logic late;     // oldest request aged out of the window
        logic ovf;      // request dropped because the queue was full
    } evt_t;

endpackage

// File: rtl/rgl_port_tracker.sv
// Per-port tracker: keeps a circular queue of ages of pending requests.
// Stored age = cycles elapsed since the request's sampling edge (1 the
// cycle after). The head is retired by a grant or when it times out.
// Assumes at most one request and one grant per cycle on this port, and
// a minimum legal latency of one cycle.
module rgl_port_tracker
    import rgl_pkg::*;
#(
    parameter int DEPTH   = 4,
    parameter int MAX_LAT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic gnt_i,
    output evt_t evt_o
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int AGE_W = $clog2(MAX_LAT + 1);

    logic [AGE_W-1:0] age_q [DEPTH];
    logic [PTR_W-1:0] rd_ptr_q, wr_ptr_q;
    logic [CNT_W-1:0] count_q;

    logic             empty, full, pop_gnt, pop, push;
    logic [AGE_W-1:0] head_age;

    // Wraps a queue pointer at DEPTH
    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    // Classifies this cycle's request and grant against the queue head
    always_comb begin
        empty        = (count_q == '0);
        full         = (count_q == CNT_W'(DEPTH));
        head_age     = age_q[rd_ptr_q];
        evt_o.orphan = gnt_i & empty & ~req_i;
        evt_o.early  = gnt_i & empty & req_i;
        pop_gnt      = gnt_i & ~empty;
        evt_o.late   = ~gnt_i & ~empty & (head_age == AGE_W'(MAX_LAT));
        pop          = pop_gnt | evt_o.late;
        evt_o.ovf    = req_i & full & ~pop;
        push         = req_i & ~evt_o.early & ~evt_o.ovf;
    end

    // Advances pointers and occupancy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr_q <= '0;
            wr_ptr_q <= '0;
            count_q  <= '0;
        end else begin
            if (pop)  rd_ptr_q <= ptr_inc(rd_ptr_q);
            if (push) wr_ptr_q <= ptr_inc(wr_ptr_q);
            count_q <= count_q + CNT_W'(push) - CNT_W'(pop);
        end
    end

    // Ages every slot by one (saturating) and loads a fresh entry at age 1
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) age_q[i] <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (push && (wr_ptr_q == PTR_W'(i)))
                    age_q[i] <= AGE_W'(1);
                else if (age_q[i] < AGE_W'(MAX_LAT))
                    age_q[i] <= age_q[i] + AGE_W'(1);
            end
        end
    end

    assert_occupancy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CNT_W'(DEPTH));

    assert_head_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (count_q != '0) |-> (head_age >= AGE_W'(1) && head_age <= AGE_W'(MAX_LAT)));

    assert_grant_retires_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_i && !req_i && count_q != '0) |=> count_q == $past(count_q) - CNT_W'(1));

    assert_late_retires_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_o.late && !req_i) |=> count_q == $past(count_q) - CNT_W'(1));

    assert_early_not_queued_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_i && req_i && count_q == '0) |=> count_q == '0);

    assert_no_overflow_growth_R7: assert property (@(posedge clk) disable iff (!rst_n)
        evt_o.ovf |=> count_q == CNT_W'(DEPTH));

endmodule

// File: rtl/rgl_sticky_err.sv
// Sticky error register bank: each bit latches a set pulse and holds it
// until a synchronous clear. A set in the clear cycle still wins.
module rgl_sticky_err #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic [W-1:0] set_i,
    output logic [W-1:0] err_o
);
    // Holds, clears and accumulates error bits
    always_ff @(posedge clk) begin
        if (!rst_n) err_o <= '0;
        else        err_o <= (clr_i ? '0 : err_o) | set_i;
    end

    assert_sticky_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> ((err_o & $past(err_o)) == $past(err_o)));

    assert_clear_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && set_i == '0) |=> err_o == '0);

endmodule

// File: rtl/reqgnt_lat_mon.sv
// Request-grant latency monitor top: one tracker per port, events
// gathered into a sticky error bank. Bit p of each error vector is
// port p. Assumes grants of a port only answer requests of that port.
module reqgnt_lat_mon
    import rgl_pkg::*;
#(
    parameter int NUM_PORTS = 2,
    parameter int DEPTH     = 4,
    parameter int MAX_LAT   = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr_i,
    input  logic [NUM_PORTS-1:0] req_i,
    input  logic [NUM_PORTS-1:0] gnt_i,
    output logic [NUM_PORTS-1:0] err_orphan_o,
    output logic [NUM_PORTS-1:0] err_early_o,
    output logic [NUM_PORTS-1:0] err_late_o,
    output logic [NUM_PORTS-1:0] err_ovf_o
);
    localparam int ERR_W = 4 * NUM_PORTS;

    evt_t                 evt [NUM_PORTS];
    logic [NUM_PORTS-1:0] set_orphan, set_early, set_late, set_ovf;
    logic [ERR_W-1:0]     err_all;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        rgl_port_tracker #(
            .DEPTH   (DEPTH),
            .MAX_LAT (MAX_LAT)
        ) u_trk (
            .clk   (clk),
            .rst_n (rst_n),
            .req_i (req_i[p]),
            .gnt_i (gnt_i[p]),
            .evt_o (evt[p])
        );
        assign set_orphan[p] = evt[p].orphan;
        assign set_early[p]  = evt[p].early;
        assign set_late[p]   = evt[p].late;
        assign set_ovf[p]    = evt[p].ovf;
    end

    rgl_sticky_err #(.W(ERR_W)) u_err (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (clr_i),
        .set_i ({set_ovf, set_late, set_early, set_orphan}),
        .err_o (err_all)
    );

    assign err_orphan_o = err_all[NUM_PORTS-1:0];
    assign err_early_o  = err_all[2*NUM_PORTS-1:NUM_PORTS];
    assign err_late_o   = err_all[3*NUM_PORTS-1:2*NUM_PORTS];
    assign err_ovf_o    = err_all[4*NUM_PORTS-1:3*NUM_PORTS];

endmodule

// File: tb/reqgnt_lat_mon_tb.sv
`timescale 1ns/1ps
module reqgnt_lat_mon_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clr = 1'b0;
    logic [1:0] req = '0;
    logic [1:0] gnt = '0;
    logic [1:0] m_or, m_ea, m_la, m_ov;   // main instance, depth 4
    logic [1:0] s_or, s_ea, s_la, s_ov;   // shallow instance, depth 2

    int    checks = 0;
    int    fails  = 0;
    bit    done   = 1'b0;
    string phase  = "R1 reset";

    always #2.5 clk = ~clk;

    reqgnt_lat_mon #(.NUM_PORTS(2), .DEPTH(4), .MAX_LAT(4)) u_dut (
        .clk(clk), .rst_n(rst_n), .clr_i(clr), .req_i(req), .gnt_i(gnt),
        .err_orphan_o(m_or), .err_early_o(m_ea), .err_late_o(m_la), .err_ovf_o(m_ov));

    reqgnt_lat_mon #(.NUM_PORTS(2), .DEPTH(2), .MAX_LAT(4)) u_dut_shallow (
        .clk(clk), .rst_n(rst_n), .clr_i(clr), .req_i(req), .gnt_i(gnt),
        .err_orphan_o(s_or), .err_early_o(s_ea), .err_late_o(s_la), .err_ovf_o(s_ov));

    // Reference model: per instance and port, a queue of request cycle numbers
    int       mq [2][2][$];
    bit [1:0] xo [2], xe [2], xl [2], xv [2];
    int       cyc = 0;

    initial begin
        for (int k = 0; k < 2; k++) begin
            xo[k] = '0; xe[k] = '0; xl[k] = '0; xv[k] = '0;
        end
    end

    always @(posedge clk) begin
        cyc++;
        for (int k = 0; k < 2; k++) begin
            for (int p = 0; p < 2; p++) begin
                bit e_o, e_e, e_l, e_v, popped;
                int dep, size0;
                dep = (k == 0) ? 4 : 2;
                e_o = 0; e_e = 0; e_l = 0; e_v = 0; popped = 0;
                if (!rst_n) begin
                    mq[k][p].delete();
                    xo[k][p] = 0; xe[k][p] = 0; xl[k][p] = 0; xv[k][p] = 0;
                end else begin
                    size0 = mq[k][p].size();
                    if (gnt[p]) begin
                        if (size0 == 0) begin
                            if (req[p]) e_e = 1; else e_o = 1;
                        end else begin
                            void'(mq[k][p].pop_front());
                            popped = 1;
                        end
                    end else if (size0 > 0 && (cyc - mq[k][p][0]) >= 4) begin
                        void'(mq[k][p].pop_front());
                        popped = 1;
                        e_l = 1;
                    end
                    if (req[p] && !e_e) begin
                        if (size0 == dep && !popped) e_v = 1;
                        else mq[k][p].push_back(cyc);
                    end
                    xo[k][p] = (clr ? 1'b0 : xo[k][p]) | e_o;
                    xe[k][p] = (clr ? 1'b0 : xe[k][p]) | e_e;
                    xl[k][p] = (clr ? 1'b0 : xl[k][p]) | e_l;
                    xv[k][p] = (clr ? 1'b0 : xv[k][p]) | e_v;
                end
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // Compares both instances against the model
    task automatic compare();
        chk({phase, " main"},    {24'd0, m_ov, m_la, m_ea, m_or}, {24'd0, xv[0], xl[0], xe[0], xo[0]});
        chk({phase, " shallow"}, {24'd0, s_ov, s_la, s_ea, s_or}, {24'd0, xv[1], xl[1], xe[1], xo[1]});
    endtask

    // One cycle: drive at a falling edge, check at the next falling edge
    task automatic step(input logic [1:0] r, input logic [1:0] g, input logic c);
        req = r; gnt = g; clr = c;
        @(negedge clk);
        compare();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(2'b00, 2'b00, 1'b0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        @(negedge clk);
        // R1: reset with requests held high
        rst_n = 1'b0;
        for (int i = 0; i < 3; i++) step(2'b11, 2'b00, 1'b0);
        chk("R1 reset errors zero", {m_ov, m_la, m_ea, m_or}, 8'h00);
        rst_n = 1'b1;
        step(2'b00, 2'b01, 1'b0);
        chk("R1 queue empty after reset", m_or, 2'b01);
        step(2'b00, 2'b00, 1'b1);

        phase = "R2 latency window";
        for (int lat = 1; lat <= 4; lat++) begin
            step(2'b01, 2'b00, 1'b0);
            idle(lat - 1);
            step(2'b00, 2'b01, 1'b0);
            chk("R2 legal latency no error", {m_ov, m_la, m_ea, m_or}, 8'h00);
        end
        idle(2);

        phase = "R3 in-order";
        step(2'b01, 2'b00, 1'b0);
        step(2'b00, 2'b00, 1'b0);
        step(2'b01, 2'b00, 1'b0);
        step(2'b00, 2'b01, 1'b0);
        step(2'b00, 2'b00, 1'b0);
        step(2'b00, 2'b01, 1'b0);
        chk("R3 ordered pairing no error", {m_ov, m_la, m_ea, m_or}, 8'h00);
        idle(2);

        phase = "R10 R7 multiple pending";
        for (int i = 0; i < 4; i++) step(2'b01, 2'b00, 1'b0);
        for (int i = 0; i < 4; i++) step(2'b00, 2'b01, 1'b0);
        chk("R10 four pending all legal", {m_ov, m_la, m_ea, m_or}, 8'h00);
        chk("R7 shallow overflow", s_ov, 2'b01);
        chk("R7 dropped request leaves orphan", s_or, 2'b01);
        idle(5);
        step(2'b00, 2'b00, 1'b1);

        phase = "R7 full with retire";
        step(2'b01, 2'b00, 1'b0);
        step(2'b01, 2'b00, 1'b0);
        step(2'b01, 2'b01, 1'b0);
        step(2'b00, 2'b01, 1'b0);
        step(2'b00, 2'b01, 1'b0);
        chk("R7 push with retire no overflow", {s_ov, s_la, s_ea, s_or}, 8'h00);
        idle(5);

        phase = "R6 timeout";
        step(2'b01, 2'b00, 1'b0);
        idle(3);
        chk("R6 age 3 not late", m_la, 2'b00);
        idle(1);
        chk("R6 late at age 4", m_la, 2'b01);
        step(2'b00, 2'b01, 1'b0);
        chk("R6 timed-out entry discarded", m_or, 2'b01);
        step(2'b00, 2'b00, 1'b1);

        phase = "R5 early";
        step(2'b01, 2'b01, 1'b0);
        chk("R5 same-cycle grant early", {m_ea, m_or}, 4'b0100);
        step(2'b00, 2'b01, 1'b0);
        chk("R5 early request not queued", m_or, 2'b01);
        step(2'b00, 2'b00, 1'b1);

        phase = "R4 orphan";
        step(2'b00, 2'b10, 1'b0);
        chk("R4 orphan on port 1", m_or, 2'b10);
        step(2'b00, 2'b00, 1'b1);

        phase = "R9 port independence";
        step(2'b01, 2'b10, 1'b0);
        chk("R9 port 1 grant does not retire port 0", m_or, 2'b10);
        step(2'b00, 2'b01, 1'b0);
        chk("R9 port 0 still matched", {m_ov[0], m_la[0], m_ea[0], m_or[0]}, 4'h0);
        step(2'b00, 2'b00, 1'b1);

        phase = "R8 sticky clear";
        step(2'b00, 2'b01, 1'b0);
        idle(3);
        chk("R8 error stays set", m_or, 2'b01);
        step(2'b00, 2'b00, 1'b1);
        chk("R8 clear empties errors", {m_ov, m_la, m_ea, m_or}, 8'h00);
        step(2'b00, 2'b10, 1'b1);
        chk("R8 event during clear kept", m_or, 2'b10);
        step(2'b00, 2'b00, 1'b1);

        phase = "R2 R3 R6 R7 random";
        for (int i = 0; i < 3000; i++) begin
            logic [1:0] r, g;
            r = {($urandom_range(0, 99) < 40), ($urandom_range(0, 99) < 40)};
            g = {($urandom_range(0, 99) < 35), ($urandom_range(0, 99) < 35)};
            step(r, g, ($urandom_range(0, 99) < 3));
        end

        finish_run();
    end
endmodule